// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block drives a parallel RGB display panel from the pixel clock domain. Two counters walk each frame line by line and pixel by pixel. The length of every horizontal and vertical segment (sync pulse, back porch, front porch and visible area) is programmable. From the counter position the block decodes the horizontal sync, vertical sync and data-enable levels, and it asks an upstream pixel source for data one clock ahead of each visible pixel.

Incoming 24-bit pixels pass through three stages before they reach the data bus. A crossbar chooses the source channel for each output lane. The kept bits of each lane can be mirrored end for end. Each lane is then cut down to the chosen colour depth and left-justified. Every sync-type output has its own polarity control. A mode pin keeps data-enable parked at its inactive level for panels that use sync timing only. The timing lengths are captured once per frame, so software may rewrite them at any time. The reset must be asserted asynchronously and released in step with the pixel clock upstream of the block.

Top module: `rgbtg_top`

## Requirements
- R1: A line lasts sync + back porch + front porch + active pixel clocks, and a frame lasts that line length times the sum of the four vertical lengths in lines, so VSYNC starts repeat at that period.
- R2: Before inversion, HSYNC is high for the first `hsync_len` clocks of every line, and VSYNC is high for whole lines during the first `vsync_len` lines of a frame.
- R3: With `sync_only` low, DE (before inversion) is high only where the horizontal position lies in [hsync+hback, hsync+hback+hactive) and the line lies in [vsync+vback, vsync+vback+vactive).
- R4: With `sync_only` high, DE stays at its inactive level (equal to `inv_de`) for the whole frame.
- R5: `inv_hsync`, `inv_vsync` and `inv_de` each invert only their own output. `dclk_fall_o` reports `inv_dclk` with one clock of latency. `dclk_en_o` is high from the first clock edge after reset.
- R6: `pix_req` is high in the clock before each visible pixel. The data bus during that pixel shows the value that `pix_in` holds in the cycle after the request, after formatting.
- R7: Outside the visible area `data_o` is all zeros.
- R8: Each output lane has a 2-bit source select: 0 takes its own input channel, 1 takes R (`pix_in[23:16]`), 2 takes G (`pix_in[15:8]`), 3 takes B (`pix_in[7:0]`). The lane order on `data_o` is R, G, B from the MSB down.
- R9: `out_fmt` 2 or 0 keeps 8 bits per lane, 1 keeps the upper 6 bits per lane, and 3 keeps 5/6/5 bits for R/G/B. The kept bits are left-justified in the 8-bit lane and the rest are zero.
- R10: With `bit_swap` high, the kept bits of each lane appear in reversed order, still left-justified.
- R11: Timing lengths are captured when the counters return to the first pixel of a frame. A change made mid-frame first takes effect at the next frame.
- R12: While reset is asserted, all sync, enable, request and data outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| hsync_len | input | 12 | Horizontal sync pulse length in clocks |
| hback_len | input | 12 | Horizontal back porch length |
| hfront_len | input | 12 | Horizontal front porch length |
| hactive_len | input | 12 | Visible pixels per line |
| vsync_len | input | 12 | Vertical sync length in lines |
| vback_len | input | 12 | Vertical back porch in lines |
| vfront_len | input | 12 | Vertical front porch in lines |
| vactive_len | input | 12 | Visible lines per frame |
| sync_only | input | 1 | 1 = keep DE inactive, sync-timed panel |
| inv_dclk | input | 1 | Dot clock launch-edge inversion |
| inv_de | input | 1 | DE polarity inversion |
| inv_hsync | input | 1 | HSYNC polarity inversion |
| inv_vsync | input | 1 | VSYNC polarity inversion |
| out_fmt | input | 2 | Depth code: 0/2 = 8-8-8, 1 = 6-6-6, 3 = 5-6-5 |
| src_r | input | 2 | Source select for the R lane |
| src_g | input | 2 | Source select for the G lane |
| src_b | input | 2 | Source select for the B lane |
| bit_swap | input | 1 | Reverse kept bits within each lane |
| pix_in | input | 24 | Pixel from the source, {R,G,B} |
| pix_req | output | 1 | Request for the next visible pixel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| dclk_en_o | output | 1 | Dot clock enable for the pad clock gate |
| dclk_fall_o | output | 1 | Dot clock launch-edge select |
| data_o | output | 24 | Formatted pixel bus |

## Verification
The hardest case to reach is a timing write that lands in the middle of a frame. The current frame must finish with the old lengths and the next one must use the new ones, and the ports show this only through where the sync and enable edges fall. The bench keeps its own frame-position model with its own captured copy of the lengths. It changes the horizontal active and vertical front porch values partway through a frame, then follows every output over the rest of that frame and two more. The formatting paths are covered by sweeping all 64 source-select combinations and every depth and reversal setting, each over a full small frame.

// File: rtl/rgbtg_pkg.sv
package rgbtg_pkg;
  parameter int unsigned TW  = 12;  // timing counter width
  parameter int unsigned CHW = 8;   // bits per colour lane
  localparam int unsigned DW = 3 * CHW;

  typedef struct packed {
    logic [TW-1:0] sw;   // sync length
    logic [TW-1:0] bp;   // back porch
    logic [TW-1:0] fp;   // front porch
    logic [TW-1:0] act;  // visible length
  } axis_t;

  typedef enum logic [1:0] {
    FMT_FULL0 = 2'd0,
    FMT_D6    = 2'd1,
    FMT_FULL  = 2'd2,
    FMT_D565  = 2'd3
  } fmt_e;
endpackage

// File: rtl/rgbtg_timebase.sv
module rgbtg_timebase import rgbtg_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  axis_t cfg_h,
  input  axis_t cfg_v,
  output logic  primed,
  output logic  hs_a,
  output logic  vs_a,
  output logic  act
);
  axis_t         sh_h, sh_v, sh_h_n, sh_v_n;
  logic [TW-1:0] h_cnt, v_cnt, h_n, v_n;
  logic          primed_n;

  axis_t         ax  [2];
  logic [TW-1:0] pos [2];
  logic [TW-1:0] tot [2];
  logic [1:0]    in_sync, in_act;

  assign ax[0]  = sh_h;
  assign ax[1]  = sh_v;
  assign pos[0] = h_cnt;
  assign pos[1] = v_cnt;

  // Identical decode for both axes.
  for (genvar i = 0; i < 2; i++) begin : g_axis
    logic [TW-1:0] lo;
    assign tot[i]     = ax[i].sw + ax[i].bp + ax[i].fp + ax[i].act;
    assign lo         = ax[i].sw + ax[i].bp;
    assign in_sync[i] = pos[i] < ax[i].sw;
    assign in_act[i]  = (pos[i] >= lo) && (pos[i] < lo + ax[i].act);
  end

  assign hs_a = primed & in_sync[0];
  assign vs_a = primed & in_sync[1];
  assign act  = primed & (&in_act);

  // Next state: first cycle out of reset captures the timing,
  // afterwards the capture happens only on the wrap to frame origin.
  always_comb begin
    primed_n = primed;
    sh_h_n   = sh_h;
    sh_v_n   = sh_v;
    h_n      = h_cnt;
    v_n      = v_cnt;
    if (!primed) begin
      primed_n = 1'b1;
      sh_h_n   = cfg_h;
      sh_v_n   = cfg_v;
      h_n      = '0;
      v_n      = '0;
    end else if (h_cnt == tot[0] - 1'b1) begin
      h_n = '0;
      if (v_cnt == tot[1] - 1'b1) begin
        v_n    = '0;
        sh_h_n = cfg_h;
        sh_v_n = cfg_v;
      end else begin
        v_n = v_cnt + 1'b1;
      end
    end else begin
      h_n = h_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      sh_h   <= '0;
      sh_v   <= '0;
      h_cnt  <= '0;
      v_cnt  <= '0;
    end else begin
      primed <= primed_n;
      sh_h   <= sh_h_n;
      sh_v   <= sh_v_n;
      h_cnt  <= h_n;
      v_cnt  <= v_n;
    end
  end

  // R1: the pixel counter never leaves the captured line length
  assert_hcnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (h_cnt < tot[0]));

  // R11: captured timing is frozen everywhere except the frame origin
  assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != '0 || v_cnt != '0) |-> ($stable(sh_h) && $stable(sh_v)));
endmodule

// File: rtl/rgbtg_pack.sv
module rgbtg_pack import rgbtg_pkg::*; (
  input  logic [DW-1:0] pix,
  input  logic [5:0]    sel,   // {B, G, R} lane selects
  input  fmt_e          fmt,
  input  logic          rev,
  input  logic          en,
  output logic [DW-1:0] data
);
  function automatic logic [CHW-1:0] flip(input logic [CHW-1:0] x);
    logic [CHW-1:0] y;
    for (int k = 0; k < CHW; k++) y[k] = x[CHW-1-k];
    return y;
  endfunction

  logic [DW-1:0] lanes;

  // Lane 0 is R at the top of the bus, lane 2 is B at the bottom.
  for (genvar ch = 0; ch < 3; ch++) begin : g_lane
    logic [1:0]     s;
    logic [CHW-1:0] x, keep_mask;
    int unsigned    src, depth;

    assign s = sel[2*ch +: 2];

    always_comb begin
      src = (s == 2'd0) ? ch : (int'(s) - 1);
      x   = pix[(2 - src) * CHW +: CHW];
      unique case (fmt)
        FMT_D6:   depth = CHW - 2;
        FMT_D565: depth = (ch == 1) ? CHW - 2 : CHW - 3;
        default:  depth = CHW;
      endcase
      keep_mask = {CHW{1'b1}} << (CHW - depth);
      if (rev) lanes[(2 - ch) * CHW +: CHW] = flip(x) << (CHW - depth);
      else     lanes[(2 - ch) * CHW +: CHW] = x & keep_mask;
    end
  end

  assign data = en ? lanes : '0;
endmodule

// File: rtl/rgbtg_top.sv
module rgbtg_top import rgbtg_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] hsync_len,
  input  logic [TW-1:0] hback_len,
  input  logic [TW-1:0] hfront_len,
  input  logic [TW-1:0] hactive_len,
  input  logic [TW-1:0] vsync_len,
  input  logic [TW-1:0] vback_len,
  input  logic [TW-1:0] vfront_len,
  input  logic [TW-1:0] vactive_len,
  input  logic          sync_only,
  input  logic          inv_dclk,
  input  logic          inv_de,
  input  logic          inv_hsync,
  input  logic          inv_vsync,
  input  logic [1:0]    out_fmt,
  input  logic [1:0]    src_r,
  input  logic [1:0]    src_g,
  input  logic [1:0]    src_b,
  input  logic          bit_swap,
  input  logic [DW-1:0] pix_in,
  output logic          pix_req,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          dclk_en_o,
  output logic          dclk_fall_o,
  output logic [DW-1:0] data_o
);
  axis_t cfg_h, cfg_v;
  logic  primed, hs_a, vs_a, act;
  logic  act_q;
  logic  hs_n, vs_n, de_n;

  assign cfg_h = '{sw: hsync_len, bp: hback_len, fp: hfront_len, act: hactive_len};
  assign cfg_v = '{sw: vsync_len, bp: vback_len, fp: vfront_len, act: vactive_len};

  rgbtg_timebase u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_h  (cfg_h),
    .cfg_v  (cfg_v),
    .primed (primed),
    .hs_a   (hs_a),
    .vs_a   (vs_a),
    .act    (act)
  );

  // Request leads the registered outputs by one clock.
  assign pix_req = act;

  always_comb begin
    hs_n = hs_a ^ inv_hsync;
    vs_n = vs_a ^ inv_vsync;
    de_n = (act & ~sync_only) ^ inv_de;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o     <= 1'b0;
      vsync_o     <= 1'b0;
      de_o        <= 1'b0;
      act_q       <= 1'b0;
      dclk_en_o   <= 1'b0;
      dclk_fall_o <= 1'b0;
    end else begin
      hsync_o     <= hs_n;
      vsync_o     <= vs_n;
      de_o        <= de_n;
      act_q       <= act;
      dclk_en_o   <= 1'b1;
      dclk_fall_o <= inv_dclk;
    end
  end

  // Pixel arrives one clock after its request; format it for this slot.
  rgbtg_pack u_pack (
    .pix  (pix_in),
    .sel  ({src_b, src_g, src_r}),
    .fmt  (fmt_e'(out_fmt)),
    .rev  (bit_swap),
    .en   (act_q),
    .data (data_o)
  );

  // R6: a request is followed by an asserted DE in DE mode
  assert_req_then_de_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(pix_req) && !$past(sync_only)) |-> (de_o != $past(inv_de)));

  // R4: sync-only mode parks DE at its inactive level
  assert_parked_de_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(sync_only)) |-> (de_o == $past(inv_de)));

  // R7: no request in the previous cycle means a blank bus now
  assert_blank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pix_req) |-> (data_o == '0));
endmodule

// File: tb/sim_rgbtg_top.sv
module sim_rgbtg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] hsw, hbp, hfp, hac, vsw, vbp, vfp, vac;
  logic        sync_only, inv_dclk, inv_de, inv_hs, inv_vs, bit_swap;
  logic [1:0]  out_fmt, src_r, src_g, src_b;
  logic [23:0] pix_in;
  logic        pix_req, hsync_o, vsync_o, de_o, dclk_en_o, dclk_fall_o;
  logic [23:0] data_o;

  always #10 clk = ~clk;  // 50 MHz

  rgbtg_top u0 (
    .clk(clk), .rst_n(rst_n),
    .hsync_len(hsw), .hback_len(hbp), .hfront_len(hfp), .hactive_len(hac),
    .vsync_len(vsw), .vback_len(vbp), .vfront_len(vfp), .vactive_len(vac),
    .sync_only(sync_only), .inv_dclk(inv_dclk), .inv_de(inv_de),
    .inv_hsync(inv_hs), .inv_vsync(inv_vs), .out_fmt(out_fmt),
    .src_r(src_r), .src_g(src_g), .src_b(src_b), .bit_swap(bit_swap),
    .pix_in(pix_in), .pix_req(pix_req), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .dclk_en_o(dclk_en_o), .dclk_fall_o(dclk_fall_o), .data_o(data_o)
  );

  int checks = 0, errors = 0;
  int mh, mv, shh[4], shv[4];
  bit fresh, p_hs, p_vs, p_act;
  int idx, ncyc, last_rise, per_chk;
  bit last_vs;
  string dtag, ttag;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, ncyc);
    end
  endtask

  function automatic logic [23:0] exp_fmt(logic [23:0] p);
    logic [23:0] o = '0;
    logic [1:0] sl [3];
    sl[0] = src_r; sl[1] = src_g; sl[2] = src_b;
    for (int ch = 0; ch < 3; ch++) begin
      int src = (sl[ch] == 0) ? ch : int'(sl[ch]) - 1;
      int d = (out_fmt == 1) ? 6 : (out_fmt == 3) ? ((ch == 1) ? 6 : 5) : 8;
      int v = (p >> (8 * (2 - src))) & 8'hFF;
      int r = 0;
      v = v >> (8 - d);
      if (bit_swap) begin
        for (int i = 0; i < d; i++) if ((v >> (d - 1 - i)) & 1) r |= (1 << i);
        v = r;
      end
      o |= 24'((v << (8 - d)) << (8 * (2 - ch)));
    end
    return o;
  endfunction

  task automatic capture();
    shh[0] = hsw; shh[1] = hbp; shh[2] = hfp; shh[3] = hac;
    shv[0] = vsw; shv[1] = vbp; shv[2] = vfp; shv[3] = vac;
  endtask

  // One clock of the reference model, then compare all outputs.
  task automatic tick();
    int ht, vt, hl, vl;
    bit c_hs, c_vs, c_act, raw_vs;
    @(negedge clk);
    ncyc++;
    if (fresh) begin
      mh = 0; mv = 0; capture(); fresh = 0;
    end else begin
      ht = shh[0] + shh[1] + shh[2] + shh[3];
      vt = shv[0] + shv[1] + shv[2] + shv[3];
      if (mh == ht - 1) begin
        mh = 0;
        if (mv == vt - 1) begin mv = 0; capture(); end   // R11 frame-origin capture
        else mv++;
      end else mh++;
    end
    hl = shh[0] + shh[1]; vl = shv[0] + shv[1];
    c_hs  = mh < shh[0];
    c_vs  = mv < shv[0];
    c_act = (mh >= hl) && (mh < hl + shh[3]) && (mv >= vl) && (mv < vl + shv[3]);

    chk({"R2 hsync ", ttag}, hsync_o, p_hs ^ inv_hs);
    chk({"R2 vsync ", ttag}, vsync_o, p_vs ^ inv_vs);
    chk(sync_only ? {"R4 de ", ttag} : {"R3 de ", ttag}, de_o, (p_act & ~sync_only) ^ inv_de);
    chk("R6 request", pix_req, c_act);
    if (p_act) chk({dtag, " data"}, data_o, exp_fmt(pix_in));
    else       chk("R7 blank data", data_o, 0);
    chk("R5 dclk_en", dclk_en_o, 1);
    chk("R5 dclk_fall", dclk_fall_o, inv_dclk);

    raw_vs = vsync_o ^ inv_vs;
    if (raw_vs && !last_vs) begin
      if (per_chk && last_rise >= 0)
        chk("R1 frame period", ncyc - last_rise,
            (shh[0] + shh[1] + shh[2] + shh[3]) * (shv[0] + shv[1] + shv[2] + shv[3]));
      last_rise = ncyc;
    end
    last_vs = raw_vs;

    p_hs = c_hs; p_vs = c_vs; p_act = c_act;
    if (c_act) begin pix_in = 24'(idx * 32'h9E3779 + 32'h51); idx++; end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  localparam int FRAME = 9 * 6;

  initial begin
    rst_n = 1'b0;
    hsw = 2; hbp = 1; hfp = 2; hac = 4;
    vsw = 1; vbp = 1; vfp = 1; vac = 3;
    sync_only = 0; inv_dclk = 0; inv_de = 0; inv_hs = 0; inv_vs = 0; bit_swap = 0;
    out_fmt = 2; src_r = 0; src_g = 0; src_b = 0; pix_in = '0;
    ncyc = 0; idx = 0; last_rise = -1; per_chk = 0; last_vs = 0;
    p_hs = 0; p_vs = 0; p_act = 0; dtag = "R6 R9"; ttag = "";
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 hsync", hsync_o, 0); chk("R12 vsync", vsync_o, 0);
    chk("R12 de", de_o, 0);       chk("R12 req", pix_req, 0);
    chk("R12 data", data_o, 0);   chk("R12 dclk_en", dclk_en_o, 0);
    rst_n = 1'b1; fresh = 1;

    // Plain DE mode, full depth, two frames with period check (R1, R3)
    per_chk = 1;
    run(3 * FRAME);
    per_chk = 0;

    // Polarity inversions in DE mode (R5)
    inv_hs = 1; inv_vs = 1; inv_de = 1; inv_dclk = 1; ttag = "R5";
    run(FRAME);
    inv_hs = 0; inv_de = 0; run(FRAME);
    inv_vs = 0; inv_de = 1; inv_dclk = 0; run(FRAME);
    inv_de = 0; ttag = "";

    // Sync-only mode, both DE polarities (R4)
    sync_only = 1; run(FRAME);
    inv_de = 1; run(FRAME);
    sync_only = 0; inv_de = 0;

    // Depth and reversal sweep (R9, R10)
    for (int f = 0; f < 4; f++)
      for (int r = 0; r < 2; r++) begin
        out_fmt = 2'(f); bit_swap = r[0];
        dtag = r ? "R10" : "R9";
        run(FRAME);
      end
    out_fmt = 2; bit_swap = 0;

    // All source-select combinations (R8)
    dtag = "R8";
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          src_r = 2'(a); src_g = 2'(b); src_b = 2'(c);
          run(FRAME);
        end
    src_r = 0; src_g = 0; src_b = 0; dtag = "R6 R9";

    // Mid-frame timing rewrite takes effect only at next frame (R11)
    run(20);
    ttag = "R11";
    hac = 5; vfp = 2; hsw = 3;
    run(FRAME + 2 * (11 * 7));
    ttag = "";

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule